// File: doc/BRIEF.md
# Protection Latch and CHR Banker

This block sits on the cartridge side of an 8-bit CPU bus and implements a small copy-protection puzzle that also selects the character-ROM bank. Software loads a six-bit value into an input latch. On that load the data lines are taken in mirrored order. A strobe then moves the value into a working register, either as a copy that can have its low nibble complemented or as a wrapping increment of the low nibble only. Software can read the working register back, and its upper two bits are complemented when the invert flag is set.

A write to the upper half of the address space commits the working register to an output latch. The low two bits of the output latch pick one of four 8 KiB character-ROM banks. The same commit loads the nametable mirroring select from the invert flag. Program ROM is a single fixed 32 KiB bank, so the block only passes the low address bits through and decodes the chip select.

Top module: `prot_chr_banker`

## Requirements
- R1: After reset (asynchronous, active low) the input latch, working register, output latch, mode flag and invert flag are all zero. `chr_bank_o` is 0 and `mirror_vert_o` is 0, where 0 means horizontal and 1 means vertical.
- R2: The register window is hit when `addr_i & 0xE100 == 0x4100`. Within it, `addr_i[1:0]` picks the sub-register: 0 is execute, 1 is invert, 2 is load and 3 is mode. Aliases such as 0x4108 and 0x41FC act exactly as the base addresses do.
- R3: A write to sub-register 2 loads the input latch so that input bit i equals `wdata_i[5-i]`, for i from 0 to 5.
- R4: A write to sub-register 1 sets invert from `wdata_i[5]`. A write to sub-register 3 sets mode from `wdata_i[5]`. All other data bits are ignored.
- R5: A write to sub-register 0 with mode 0 loads the working register from the input latch. When invert is 1, bits [3:0] are complemented on the way. The write data is ignored.
- R6: A write to sub-register 0 with mode 1 adds one to working register bits [3:0], wrapping from 0xF to 0x0. Bits [5:4] and the input latch are left unchanged.
- R7: A read in the window drives `rdata_oe_o` high. `rdata_o[5:0]` then shows the working register with bits [5:4] complemented when invert is 1, and `rdata_o[7:6]` equals `open_bus_i[7:6]`. Outside window reads, `rdata_oe_o` is 0 and `rdata_o` equals `open_bus_i`.
- R8: Any write with `addr_i[15]=1`, whatever its data, copies the working register into the output latch and sets `mirror_vert_o` to the invert flag.
- R9: `chr_bank_o` equals output latch bits [1:0]. `prg_addr_o` equals `addr_i[14:0]`, and `prg_cs_o` equals `rd_i & addr_i[15]`.
- R10: A write that hits neither the window nor the upper half of the address space changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_i | input | 1 | Read strobe |
| open_bus_i | input | 8 | Value left on the undriven data lines |
| rdata_o | output | 8 | Read data |
| rdata_oe_o | output | 1 | Read data drive enable |
| prg_addr_o | output | 15 | Offset into the fixed program ROM bank |
| prg_cs_o | output | 1 | Program ROM select |
| chr_bank_o | output | 2 | Character-ROM 8 KiB bank number |
| mirror_vert_o | output | 1 | Mirroring select: 1 vertical, 0 horizontal |

## Verification
Every write lands on the rising edge that samples `wr_i`. Its effect on `chr_bank_o`, `mirror_vert_o` or the read-back value is therefore due one edge after the strobe is driven, and the bench drives on a falling edge and checks on the next falling edge. Reads and the program ROM outputs are combinational, so they are checked 1 ns after the address and strobe settle, within the same low phase. The contents of the input latch are observed through an execute strobe in copy mode followed by a window read.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int ADDR_WIDTH  = 16;
  localparam int DATA_WIDTH  = 8;
  localparam int LATCH_WIDTH = 6;
  localparam int NIB_WIDTH   = 4;
  localparam int CHR_WIDTH   = 2;
  localparam int PRG_WIDTH   = 15;
  localparam int FLAG_BIT    = 5;
  localparam logic [ADDR_WIDTH-1:0] WIN_MASK  = 16'hE100;
  localparam logic [ADDR_WIDTH-1:0] WIN_MATCH = 16'h4100;

  typedef enum logic [1:0] {
    SUB_EXEC = 2'd0,
    SUB_INV  = 2'd1,
    SUB_LOAD = 2'd2,
    SUB_MODE = 2'd3
  } sub_e;
endpackage

// File: rtl/prot_decode.sv
module prot_decode
  import prot_pkg::*;
#(
  parameter int ADDR_W = ADDR_WIDTH
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              win_o,
  output sub_e              sub_o,
  output logic              commit_o
);
  assign win_o    = (addr_i & WIN_MASK) == WIN_MATCH;
  assign sub_o    = sub_e'(addr_i[1:0]);
  assign commit_o = addr_i[ADDR_W-1];
endmodule

// File: rtl/prot_regs.sv
module prot_regs
  import prot_pkg::*;
#(
  parameter int DATA_W  = DATA_WIDTH,
  parameter int LATCH_W = LATCH_WIDTH,
  parameter int NIB_W   = NIB_WIDTH,
  parameter int FLAG_B  = FLAG_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               win_i,
  input  sub_e               sub_i,
  input  logic               commit_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [LATCH_W-1:0] in_q_o,
  output logic [LATCH_W-1:0] work_q_o,
  output logic [LATCH_W-1:0] out_q_o,
  output logic               mode_q_o,
  output logic               inv_q_o,
  output logic               mirror_q_o
);
  localparam int HI_W = LATCH_W - NIB_W;

  logic [LATCH_W-1:0] rev_d, work_d;
  logic               wr_win, wr_commit;
  logic               unused_data;

  // data lane i feeds latch bit LATCH_W-1-i
  for (genvar i = 0; i < LATCH_W; i++) begin : g_rev
    assign rev_d[i] = wdata_i[LATCH_W-1-i];
  end

  assign unused_data = ^wdata_i[DATA_W-1:LATCH_W];
  assign wr_win      = wr_i & win_i;
  assign wr_commit   = wr_i & commit_i & ~win_i;

  always_comb begin
    if (mode_q_o) begin
      work_d = {work_q_o[LATCH_W-1:NIB_W], work_q_o[NIB_W-1:0] + NIB_W'(1)};
    end else begin
      work_d = in_q_o ^ {{HI_W{1'b0}}, {NIB_W{inv_q_o}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q_o     <= '0;
      work_q_o   <= '0;
      out_q_o    <= '0;
      mode_q_o   <= 1'b0;
      inv_q_o    <= 1'b0;
      mirror_q_o <= 1'b0;
    end else if (wr_win) begin
      unique case (sub_i)
        SUB_EXEC: work_q_o <= work_d;
        SUB_INV:  inv_q_o  <= wdata_i[FLAG_B];
        SUB_LOAD: in_q_o   <= rev_d;
        SUB_MODE: mode_q_o <= wdata_i[FLAG_B];
        default:  ;
      endcase
    end else if (wr_commit) begin
      out_q_o    <= work_q_o;
      mirror_q_o <= inv_q_o;
    end
  end
endmodule

// File: rtl/prot_readback.sv
module prot_readback
  import prot_pkg::*;
#(
  parameter int DATA_W  = DATA_WIDTH,
  parameter int LATCH_W = LATCH_WIDTH,
  parameter int NIB_W   = NIB_WIDTH
) (
  input  logic               rd_i,
  input  logic               win_i,
  input  logic               inv_i,
  input  logic [LATCH_W-1:0] work_i,
  input  logic [DATA_W-1:0]  open_bus_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               oe_o
);
  localparam int HI_W = LATCH_W - NIB_W;

  logic [LATCH_W-1:0] view;

  assign view    = work_i ^ {{HI_W{inv_i}}, {NIB_W{1'b0}}};
  assign oe_o    = rd_i & win_i;
  assign rdata_o = oe_o ? {open_bus_i[DATA_W-1:LATCH_W], view} : open_bus_i;
endmodule

// File: rtl/prot_chr_banker.sv
module prot_chr_banker
  import prot_pkg::*;
#(
  parameter int ADDR_W  = ADDR_WIDTH,
  parameter int DATA_W  = DATA_WIDTH,
  parameter int LATCH_W = LATCH_WIDTH,
  parameter int NIB_W   = NIB_WIDTH,
  parameter int CHR_W   = CHR_WIDTH,
  parameter int PRG_W   = PRG_WIDTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] open_bus_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic [PRG_W-1:0]  prg_addr_o,
  output logic              prg_cs_o,
  output logic [CHR_W-1:0]  chr_bank_o,
  output logic              mirror_vert_o
);
  logic               win, commit;
  sub_e               sub;
  logic [LATCH_W-1:0] in_q, work_q, out_q;
  logic               mode_q, inv_q, mirror_q;
  logic               unused_out;

  prot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .win_o    (win),
    .sub_o    (sub),
    .commit_o (commit)
  );

  prot_regs #(
    .DATA_W (DATA_W),
    .LATCH_W(LATCH_W),
    .NIB_W  (NIB_W),
    .FLAG_B (FLAG_BIT)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .win_i     (win),
    .sub_i     (sub),
    .commit_i  (commit),
    .wdata_i   (wdata_i),
    .in_q_o    (in_q),
    .work_q_o  (work_q),
    .out_q_o   (out_q),
    .mode_q_o  (mode_q),
    .inv_q_o   (inv_q),
    .mirror_q_o(mirror_q)
  );

  prot_readback #(
    .DATA_W (DATA_W),
    .LATCH_W(LATCH_W),
    .NIB_W  (NIB_W)
  ) u_rb (
    .rd_i      (rd_i),
    .win_i     (win),
    .inv_i     (inv_q),
    .work_i    (work_q),
    .open_bus_i(open_bus_i),
    .rdata_o   (rdata_o),
    .oe_o      (rdata_oe_o)
  );

  // upper output latch bits only exist for the commit path
  assign unused_out    = ^out_q[LATCH_W-1:CHR_W];
  assign chr_bank_o    = out_q[CHR_W-1:0];
  assign mirror_vert_o = mirror_q;
  assign prg_addr_o    = addr_i[PRG_W-1:0];
  assign prg_cs_o      = rd_i & addr_i[ADDR_W-1];
endmodule

// File: rtl/prot_chr_banker_chk.sv
module prot_chr_banker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [5:0]  wd_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [1:0]  ob_hi_i,
  input logic [1:0]  rd_hi_i,
  input logic        oe_i,
  input logic [1:0]  chr_i,
  input logic        mirror_i,
  input logic [5:0]  in_q,
  input logic [5:0]  work_q,
  input logic        mode_q,
  input logic        inv_q
);
  logic       hit;
  logic [5:0] wd_rev;

  assign hit    = (addr_i & 16'hE100) == 16'h4100;
  assign wd_rev = {wd_i[0], wd_i[1], wd_i[2], wd_i[3], wd_i[4], wd_i[5]};

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (chr_i == 2'd0 && !mirror_i && work_q == 6'd0));

  p_load_rev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && addr_i[1:0] == 2'd2) |=> in_q == $past(wd_rev));

  p_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && addr_i[1:0] == 2'd0 && !mode_q)
      |=> work_q == ($past(in_q) ^ {2'b00, {4{$past(inv_q)}}}));

  p_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && addr_i[1:0] == 2'd0 && mode_q)
      |=> (work_q[5:4] == $past(work_q[5:4]) &&
           work_q[3:0] == $past(work_q[3:0]) + 4'd1 && $stable(in_q)));

  p_bus_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> rd_hi_i == ob_hi_i);

  p_no_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> !oe_i);

  p_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15]) |=> (mirror_i == $past(inv_q) && chr_i == $past(work_q[1:0])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i[15] && !hit)
      |=> ($stable(work_q) && $stable(in_q) && $stable(mode_q) && $stable(inv_q) &&
           $stable(chr_i) && $stable(mirror_i)));
endmodule

bind prot_chr_banker prot_chr_banker_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wd_i    (wdata_i[5:0]),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .ob_hi_i (open_bus_i[7:6]),
  .rd_hi_i (rdata_o[7:6]),
  .oe_i    (rdata_oe_o),
  .chr_i   (chr_bank_o),
  .mirror_i(mirror_vert_o),
  .in_q    (in_q),
  .work_q  (work_q),
  .mode_q  (mode_q),
  .inv_q   (inv_q)
);

// File: tb/sim_prot_chr_banker.sv
`timescale 1ns / 1ps
module sim_prot_chr_banker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  open_bus_i = '0;
  logic [7:0]  rdata_o;
  logic        rdata_oe_o;
  logic [14:0] prg_addr_o;
  logic        prg_cs_o;
  logic [1:0]  chr_bank_o;
  logic        mirror_vert_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  prot_chr_banker u0 (.*);

  // op 0 write, 1 read (d = open bus, e = {oe, rdata}), 2 outputs (e[2:0] = {mirror, chr})
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] a;
    logic [7:0]  d;
    logic [8:0]  e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h4100, 8'h00, 9'h100, 4'd1},  // R1 read after reset
    '{2'd2, 16'h0000, 8'h00, 9'h000, 4'd1},  // R1 outputs after reset
    '{2'd0, 16'h4102, 8'h2A, 9'h000, 4'd3},  // R3 load -> 0x15
    '{2'd0, 16'h4100, 8'h00, 9'h000, 4'd5},  // R5 copy
    '{2'd1, 16'h4100, 8'hC0, 9'h1D5, 4'd3},  // R3 R7
    '{2'd0, 16'h4101, 8'h20, 9'h000, 4'd4},  // R4 invert on
    '{2'd0, 16'h4100, 8'hFF, 9'h000, 4'd5},  // R5 copy, nibble complemented -> 0x1A
    '{2'd1, 16'h4101, 8'h40, 9'h16A, 4'd7},  // R7 upper bits complemented on read
    '{2'd0, 16'h8000, 8'h00, 9'h000, 4'd8},  // R8 commit
    '{2'd2, 16'h0000, 8'h00, 9'h006, 4'd8},  // R8 vertical, bank 2
    '{2'd0, 16'h4103, 8'h20, 9'h000, 4'd4},  // R4 mode on
    '{2'd0, 16'h4100, 8'h00, 9'h000, 4'd6},  // R6 inc -> 0x1B
    '{2'd1, 16'h4100, 8'h00, 9'h12B, 4'd6},  // R6
    '{2'd0, 16'h4101, 8'h00, 9'h000, 4'd4},  // R4 invert off
    '{2'd1, 16'h4108, 8'h80, 9'h19B, 4'd2},  // R2 alias read
    '{2'd0, 16'h4102, 8'h3C, 9'h000, 4'd3},  // R3 load -> 0x0F
    '{2'd0, 16'h4103, 8'h00, 9'h000, 4'd4},  // R4 mode off
    '{2'd0, 16'h41FC, 8'h00, 9'h000, 4'd2},  // R2 alias execute -> 0x0F
    '{2'd0, 16'h4103, 8'h20, 9'h000, 4'd4},  // R4 mode on
    '{2'd0, 16'h4100, 8'h00, 9'h000, 4'd6},  // R6 wrap -> 0x00
    '{2'd1, 16'h4100, 8'h00, 9'h100, 4'd6},  // R6
    '{2'd0, 16'h6103, 8'h00, 9'h000, 4'd10}, // R10 outside window
    '{2'd0, 16'h7FFF, 8'h00, 9'h000, 4'd10}, // R10
    '{2'd0, 16'h4000, 8'h20, 9'h000, 4'd10}, // R10
    '{2'd2, 16'h0000, 8'h00, 9'h006, 4'd10}, // R10 no commit happened
    '{2'd0, 16'h4100, 8'h00, 9'h000, 4'd10}, // R10 mode still 1 -> 0x01
    '{2'd1, 16'h4100, 8'h00, 9'h101, 4'd10}, // R10
    '{2'd1, 16'h4000, 8'h5A, 9'h05A, 4'd7},  // R7 no drive outside window
    '{2'd0, 16'hFFFF, 8'h55, 9'h000, 4'd8},  // R8 commit, data ignored
    '{2'd2, 16'h0000, 8'h00, 9'h001, 4'd9}   // R9 horizontal, bank 1
  };

  task automatic check(input bit ok, input int r, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [7:0] ob, input logic [8:0] e,
                         input int r);
    @(negedge clk_i);
    addr_i = a; open_bus_i = ob; rd_i = 1'b1;
    #1;
    check({rdata_oe_o, rdata_o} == e, r, {7'd0, rdata_oe_o, rdata_o}, {7'd0, e});
    rd_i = 1'b0;
  endtask

  task automatic chk_out(input logic [2:0] e, input int r);
    @(negedge clk_i);
    check({mirror_vert_o, chr_bank_o} == e, r, {13'd0, mirror_vert_o, chr_bank_o}, {13'd0, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: do_write(VEC[i].a, VEC[i].d);
        2'd1: do_read(VEC[i].a, VEC[i].d, VEC[i].e, int'(VEC[i].r));
        default: chk_out(VEC[i].e[2:0], int'(VEC[i].r));
      endcase
    end

    // R6: wrap keeps bits [5:4]
    do_write(16'h4102, 8'h3F);
    do_write(16'h4103, 8'h00);
    do_write(16'h4100, 8'h00);
    do_write(16'h4103, 8'h20);
    do_write(16'h4100, 8'h00);
    do_read(16'h4100, 8'h00, 9'h130, 6);

    // R9: fixed program ROM pass-through
    @(negedge clk_i);
    addr_i = 16'h8123; rd_i = 1'b1;
    #1;
    check(prg_addr_o == 15'h0123 && prg_cs_o, 9, {prg_cs_o, prg_addr_o}, 16'h8123);
    addr_i = 16'h4100;
    #1;
    check(!prg_cs_o, 9, {15'd0, prg_cs_o}, 16'd0);
    rd_i = 1'b0;

    // R1: reset mid-run (bank 1, mode 1 before)
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(chr_bank_o == 2'd0 && !mirror_vert_o, 1, {14'd0, mirror_vert_o, chr_bank_o[0]}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_write(16'h4100, 8'h00);            // mode 0 copies cleared input
    do_read(16'h4100, 8'h00, 9'h100, 1);  // invert cleared too
    do_write(16'h8000, 8'h00);
    chk_out(3'b000, 1);

    finish_run();
  end
endmodule